// File: doc/BRIEF.md
# Hashed Direct-Mapped Instruction Translation Buffer

This block translates instruction-fetch effective addresses to real addresses through a small direct-mapped table of page translations. The slot for an address is chosen by folding several equal-width fields of the effective page number together with XOR. Each slot therefore only keeps the upper address bits that the fold does not already determine. A lookup is purely combinational on the current fetch address. It returns the real address, a hit flag and a fetch-failed flag. Fetch-failed is raised when translation is on and either no slot matches or the page is marked supervisor-only while the fetch runs in problem state.

Slots are filled from a reload port fed by the memory-management unit. A reload whose page entry could never allow execution is dropped. A separate invalidate port clears whichever slot the given address hashes to, and it does not look at the slot's stored tag. The translate-enable and privilege flags are sampled only together with a fetch redirect. Changes to them in between have no effect until the next redirect.

Top module: `ifetch_tlb`

## Requirements
- R1: After a synchronous reset every slot is empty, translation is off and the privilege flag is 1 (supervisor), so the block reports neither hit nor fetch-failed.
- R2: While translation is off, `real_addr_o` equals `fetch_ea_i`, and `hit_o` and `fetch_fail_o` are 0.
- R3: With the default parameters there are 64 slots. The slot index is `ea[17:12] ^ ea[23:18] ^ ea[29:24]`, and the stored tag is `ea[31:18]`.
- R4: With translation on, a hit needs a valid slot whose tag equals `fetch_ea_i[31:18]`. On a hit, `real_addr_o` is `{pte[31:12], fetch_ea_i[11:0]}`. Two addresses with the same index but different tags never both hit.
- R5: With translation on, a lookup that misses raises `fetch_fail_o`. `fetch_fail_o` is never 1 while translation is off.
- R6: PTE bit 3 marks a supervisor-only page. A hit on such a page while the privilege flag is 0 raises `fetch_fail_o`, and `hit_o` stays 1. With the privilege flag at 1 the same hit does not fail.
- R7: A reload is written only if PTE bit 0 and PTE bit 8 are both 1. A rejected reload leaves the target slot unchanged.
- R8: An invalidate clears the slot at the hashed index of `inval_ea_i` whatever tag that slot holds. If an invalidate and a reload land on the same slot in one cycle, the invalidate wins.
- R9: `redir_virt_i` and `redir_priv_i` are captured only in a cycle with `redirect_i` = 1, and they apply from the next cycle on. In any other cycle they have no effect.
- R10: A slot written or cleared in one cycle shows the new contents to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| redirect_i | input | 1 | Fetch redirect; samples the mode flags |
| redir_virt_i | input | 1 | Translation enable delivered with a redirect |
| redir_priv_i | input | 1 | Privilege flag delivered with a redirect (1 = supervisor) |
| fetch_ea_i | input | ADDR_W | Effective address of the current fetch |
| real_addr_o | output | ADDR_W | Translated (or passed-through) real address |
| hit_o | output | 1 | Translation on and a matching slot found |
| fetch_fail_o | output | 1 | Miss or privilege violation while translating |
| reload_i | input | 1 | Write a translation |
| reload_ea_i | input | ADDR_W | Effective address of the translation being loaded |
| reload_pte_i | input | PTE_W | Page table entry being loaded |
| inval_i | input | 1 | Clear one slot |
| inval_ea_i | input | ADDR_W | Address whose hashed slot is cleared |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 4 KiB pages, 6-bit index fields and three folded fields. With these values a handful of hand-made addresses is enough to land two different tags on one slot. Flipping address bit 12 together with bit 18 keeps the index and changes the tag, which makes the blind invalidate and the tag compare directly observable. The random phase draws from a small address pool, so reloads, invalidates and lookups keep meeting on the same slots. Supervisor-only pages and rejected PTEs come up often, and redirects change both mode flags at random.

// File: rtl/ifetch_tlb_pkg.sv
package ifetch_tlb_pkg;
   // PTE bit positions consumed by the translation buffer
   localparam int PTE_EXEC_BIT = 0;   // execute allowed for some context
   localparam int PTE_PRIV_BIT = 3;   // supervisor-only page
   localparam int PTE_REF_BIT  = 8;   // referenced / usable

   typedef struct packed {
      logic virt;   // translation enabled
      logic priv;   // 1 = supervisor, 0 = problem state
   } fetch_mode_t;
endpackage

// File: rtl/ifetch_tlb_hash.sv
module ifetch_tlb_hash #(
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 12,
   parameter int IDX_W     = 6,
   parameter int FIELDS    = 3
) (
   input  logic [ADDR_W-1:0] ea_i,
   output logic [IDX_W-1:0]  idx_o
);
   localparam int FOLD_TOP = PAGE_BITS + FIELDS * IDX_W;

   logic [IDX_W-1:0] fold [FIELDS+1];

   assign fold[0] = '0;

   generate
      for (genvar f = 0; f < FIELDS; f++) begin : g_fold
         assign fold[f+1] = fold[f] ^ ea_i[PAGE_BITS + f*IDX_W +: IDX_W];
      end
   endgenerate

   assign idx_o = fold[FIELDS];

   logic unused_ea_bits;
   assign unused_ea_bits = ^ea_i;
endmodule

// File: rtl/ifetch_tlb_array.sv
module ifetch_tlb_array #(
   parameter int IDX_W = 6,
   parameter int TAG_W = 14,
   parameter int RPN_W = 20
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic             rd_vld_o,
   output logic [TAG_W-1:0] rd_tag_o,
   output logic [RPN_W-1:0] rd_rpn_o,
   output logic             rd_prv_o,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [TAG_W-1:0] wr_tag_i,
   input  logic [RPN_W-1:0] wr_rpn_i,
   input  logic             wr_prv_i,
   input  logic             clr_en_i,
   input  logic [IDX_W-1:0] clr_idx_i
);
   localparam int ENTRIES = 1 << IDX_W;

   logic             vld [ENTRIES];
   logic [TAG_W-1:0] tag [ENTRIES];
   logic [RPN_W-1:0] rpn [ENTRIES];
   logic             prv [ENTRIES];

   // valid bits: reset, set by write, cleared by invalidate (clear wins)
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < ENTRIES; i++) vld[i] <= 1'b0;
      end else begin
         if (wr_en_i)  vld[wr_idx_i]  <= 1'b1;
         if (clr_en_i) vld[clr_idx_i] <= 1'b0;
      end
   end

   // payload needs no reset; it is qualified by the valid bit
   always_ff @(posedge clk) begin
      if (wr_en_i) begin
         tag[wr_idx_i] <= wr_tag_i;
         rpn[wr_idx_i] <= wr_rpn_i;
         prv[wr_idx_i] <= wr_prv_i;
      end
   end

   assign rd_vld_o = vld[rd_idx_i];
   assign rd_tag_o = tag[rd_idx_i];
   assign rd_rpn_o = rpn[rd_idx_i];
   assign rd_prv_o = prv[rd_idx_i];
endmodule

// File: rtl/ifetch_tlb_mode.sv
module ifetch_tlb_mode
   import ifetch_tlb_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        redirect_i,
   input  logic        virt_i,
   input  logic        priv_i,
   output fetch_mode_t mode_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         mode_o.virt <= 1'b0;
         mode_o.priv <= 1'b1;
      end else if (redirect_i) begin
         mode_o.virt <= virt_i;
         mode_o.priv <= priv_i;
      end
   end
endmodule

// File: rtl/ifetch_tlb.sv
module ifetch_tlb
   import ifetch_tlb_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int PAGE_BITS   = 12,
   parameter int IDX_W       = 6,
   parameter int HASH_FIELDS = 3,
   parameter int PTE_W       = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              redirect_i,
   input  logic              redir_virt_i,
   input  logic              redir_priv_i,
   input  logic [ADDR_W-1:0] fetch_ea_i,
   output logic [ADDR_W-1:0] real_addr_o,
   output logic              hit_o,
   output logic              fetch_fail_o,
   input  logic              reload_i,
   input  logic [ADDR_W-1:0] reload_ea_i,
   input  logic [PTE_W-1:0]  reload_pte_i,
   input  logic              inval_i,
   input  logic [ADDR_W-1:0] inval_ea_i
);
   localparam int TAG_W = ADDR_W - PAGE_BITS - IDX_W;
   localparam int RPN_W = ADDR_W - PAGE_BITS;

   initial begin
      if (PAGE_BITS + HASH_FIELDS * IDX_W > ADDR_W)
         $fatal(1, "hash fields exceed the address width");
      if (PTE_W < ADDR_W)
         $fatal(1, "PTE narrower than the real address");
      if (PTE_W <= PTE_REF_BIT)
         $fatal(1, "PTE too narrow for its flag bits");
   end

   fetch_mode_t mode;
   logic mode_virt, mode_priv;

   ifetch_tlb_mode u_mode (
      .clk        (clk),
      .rst        (rst),
      .redirect_i (redirect_i),
      .virt_i     (redir_virt_i),
      .priv_i     (redir_priv_i),
      .mode_o     (mode)
   );
   assign mode_virt = mode.virt;
   assign mode_priv = mode.priv;

   logic [IDX_W-1:0] look_idx, load_idx, kill_idx;

   ifetch_tlb_hash #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W), .FIELDS(HASH_FIELDS))
      u_hash_look (.ea_i(fetch_ea_i),  .idx_o(look_idx));
   ifetch_tlb_hash #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W), .FIELDS(HASH_FIELDS))
      u_hash_load (.ea_i(reload_ea_i), .idx_o(load_idx));
   ifetch_tlb_hash #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W), .FIELDS(HASH_FIELDS))
      u_hash_kill (.ea_i(inval_ea_i),  .idx_o(kill_idx));

   // a PTE that no context can execute from never occupies a slot
   logic load_ok;
   assign load_ok = reload_i && reload_pte_i[PTE_EXEC_BIT] && reload_pte_i[PTE_REF_BIT];

   logic             slot_vld, slot_prv;
   logic [TAG_W-1:0] slot_tag;
   logic [RPN_W-1:0] slot_rpn;

   ifetch_tlb_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .RPN_W(RPN_W)) u_array (
      .clk       (clk),
      .rst       (rst),
      .rd_idx_i  (look_idx),
      .rd_vld_o  (slot_vld),
      .rd_tag_o  (slot_tag),
      .rd_rpn_o  (slot_rpn),
      .rd_prv_o  (slot_prv),
      .wr_en_i   (load_ok),
      .wr_idx_i  (load_idx),
      .wr_tag_i  (reload_ea_i[ADDR_W-1 -: TAG_W]),
      .wr_rpn_i  (reload_pte_i[PAGE_BITS +: RPN_W]),
      .wr_prv_i  (reload_pte_i[PTE_PRIV_BIT]),
      .clr_en_i  (inval_i),
      .clr_idx_i (kill_idx)
   );

   logic tag_match, priv_block;
   assign tag_match  = slot_vld && (slot_tag == fetch_ea_i[ADDR_W-1 -: TAG_W]);
   assign priv_block = slot_prv && !mode_priv;

   assign hit_o        = mode_virt && tag_match;
   assign fetch_fail_o = mode_virt && (!tag_match || priv_block);
   assign real_addr_o  = mode_virt ? {slot_rpn, fetch_ea_i[PAGE_BITS-1:0]} : fetch_ea_i;

   logic unused_in_bits;
   assign unused_in_bits = ^{reload_pte_i, reload_ea_i[PAGE_BITS-1:0], inval_ea_i};
endmodule

// File: rtl/ifetch_tlb_chk.sv
module ifetch_tlb_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              redirect_i,
   input logic              redir_virt_i,
   input logic [ADDR_W-1:0] fetch_ea_i,
   input logic [ADDR_W-1:0] real_addr_o,
   input logic              hit_o,
   input logic              fetch_fail_o,
   input logic              inval_i,
   input logic [ADDR_W-1:0] inval_ea_i,
   input logic              mode_virt,
   input logic              mode_priv
);
   AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !hit_o && !fetch_fail_o);  // R1

   AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (rst)
      redirect_i && !redir_virt_i |=> !fetch_fail_o && !hit_o && real_addr_o == fetch_ea_i);  // R2

   AST_FAIL_NEEDS_VIRT: assert property (@(posedge clk) disable iff (rst)
      fetch_fail_o |-> mode_virt);  // R5

   AST_SUPER_HIT_OK: assert property (@(posedge clk) disable iff (rst)
      hit_o && mode_priv |-> !fetch_fail_o);  // R6

   AST_INVAL_MISS: assert property (@(posedge clk) disable iff (rst)
      $past(inval_i) && $past(inval_ea_i) == fetch_ea_i |-> !hit_o);  // R8

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !redirect_i |=> $stable(mode_virt) && $stable(mode_priv));  // R9
endmodule

bind ifetch_tlb ifetch_tlb_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .redirect_i   (redirect_i),
   .redir_virt_i (redir_virt_i),
   .fetch_ea_i   (fetch_ea_i),
   .real_addr_o  (real_addr_o),
   .hit_o        (hit_o),
   .fetch_fail_o (fetch_fail_o),
   .inval_i      (inval_i),
   .inval_ea_i   (inval_ea_i),
   .mode_virt    (mode_virt),
   .mode_priv    (mode_priv)
);

// File: tb/ifetch_tlb_tb_top.sv
module ifetch_tlb_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        redirect_i, redir_virt_i, redir_priv_i;
   logic [31:0] fetch_ea_i, reload_ea_i, inval_ea_i;
   logic [63:0] reload_pte_i;
   logic        reload_i, inval_i;
   logic [31:0] real_addr_o;
   logic        hit_o, fetch_fail_o;

   always #4 clk = ~clk;   // 125 MHz

   ifetch_tlb dut_i (.*);

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // reference model
   bit          m_vld [64];
   bit [13:0]   m_tag [64];
   bit [19:0]   m_rpn [64];
   bit          m_prv [64];
   bit          m_virt, m_priv;

   function automatic bit [5:0] slot_of(input bit [31:0] ea);
      return ea[17:12] ^ ea[23:18] ^ ea[29:24];
   endfunction

   function automatic bit [63:0] mk_pte(input bit [19:0] rpn, input bit x, input bit r, input bit p);
      bit [63:0] v = 64'(rpn) << 12;
      v[0] = x; v[8] = r; v[3] = p;
      return v;
   endfunction

   task automatic idle_inputs();
      redirect_i = 0; redir_virt_i = 0; redir_priv_i = 0;
      reload_i = 0; reload_ea_i = '0; reload_pte_i = '0;
      inval_i = 0; inval_ea_i = '0;
   endtask

   // called at a negedge with inputs set; checks, updates model, moves to next negedge
   task automatic tick(input string req);
      bit [5:0]  s;
      bit        th, e_hit, e_fail;
      bit [31:0] e_ra;
      bit        bad;
      #1;
      s = slot_of(fetch_ea_i);
      th = m_vld[s] && (m_tag[s] == fetch_ea_i[31:18]);
      if (!m_virt) begin
         e_hit = 0; e_fail = 0; e_ra = fetch_ea_i;
      end else begin
         e_hit = th; e_fail = !th || (m_prv[s] && !m_priv);
         e_ra = {m_rpn[s], fetch_ea_i[11:0]};
      end
      bad = (hit_o !== e_hit) || (fetch_fail_o !== e_fail) ||
            ((!m_virt || th) && real_addr_o !== e_ra);
      n_tests++;
      if (bad) begin
         n_fail++;
         $display("FAIL %s ea=%h: hit/fail/ra = %b/%b/%h expected %b/%b/%h",
                  req, fetch_ea_i, hit_o, fetch_fail_o, real_addr_o, e_hit, e_fail, e_ra);
      end
      if (redirect_i) begin m_virt = redir_virt_i; m_priv = redir_priv_i; end
      if (reload_i && reload_pte_i[0] && reload_pte_i[8]) begin
         s = slot_of(reload_ea_i);
         m_vld[s] = 1; m_tag[s] = reload_ea_i[31:18];
         m_rpn[s] = reload_pte_i[31:12]; m_prv[s] = reload_pte_i[3];
      end
      if (inval_i) m_vld[slot_of(inval_ea_i)] = 0;
      @(negedge clk);
      idle_inputs();
   endtask

   localparam bit [31:0] EA_A  = 32'h0123_4A10;
   localparam bit [31:0] EA_A2 = EA_A ^ 32'h0004_1000;   // same slot, other tag
   localparam bit [31:0] EA_B  = 32'h3456_7004;
   localparam bit [31:0] EA_C  = 32'h0ABC_D120;
   localparam bit [31:0] EA_D  = 32'h1111_1FF8;

   bit [31:0] pool [8];

   initial begin
      for (int i = 0; i < 64; i++) m_vld[i] = 0;
      m_virt = 0; m_priv = 1;
      idle_inputs();
      fetch_ea_i = EA_A;
      rst = 1;
      repeat (4) @(negedge clk);
      rst = 0;

      tick("R1");                                    // empty, translation off
      fetch_ea_i = EA_B; tick("R2");
      reload_i = 1; reload_ea_i = EA_A; reload_pte_i = mk_pte(20'h12345, 1, 1, 0);
      fetch_ea_i = EA_A; tick("R2");                 // translation still off
      redirect_i = 1; redir_virt_i = 1; redir_priv_i = 0;
      fetch_ea_i = EA_A; tick("R9");                 // flags not yet applied
      fetch_ea_i = EA_A; tick("R4");                 // hit
      fetch_ea_i = EA_A | 32'h0000_0FFF; tick("R3"); // offset passes through
      fetch_ea_i = EA_A ^ 32'h4000_0000; tick("R4"); // tag bit 30 differs
      fetch_ea_i = EA_B; tick("R5");                 // miss fails
      redir_virt_i = 0; fetch_ea_i = EA_B; tick("R9");
      fetch_ea_i = EA_B; tick("R9");                 // still translating
      reload_i = 1; reload_ea_i = EA_C; reload_pte_i = mk_pte(20'hCAFE0, 1, 1, 1);
      fetch_ea_i = EA_C; tick("R10");                // not yet visible
      fetch_ea_i = EA_C; tick("R6");                 // supervisor page, problem state
      redirect_i = 1; redir_virt_i = 1; redir_priv_i = 1;
      fetch_ea_i = EA_C; tick("R6");
      fetch_ea_i = EA_C; tick("R6");                 // now permitted
      reload_i = 1; reload_ea_i = EA_D; reload_pte_i = mk_pte(20'h0D0D0, 0, 1, 0);
      fetch_ea_i = EA_D; tick("R7");
      reload_i = 1; reload_ea_i = EA_D; reload_pte_i = mk_pte(20'h0D0D0, 1, 0, 0);
      fetch_ea_i = EA_D; tick("R7");
      fetch_ea_i = EA_D; tick("R7");                 // both rejected: miss
      reload_i = 1; reload_ea_i = EA_A; reload_pte_i = mk_pte(20'h77777, 0, 0, 0);
      fetch_ea_i = EA_A; tick("R7");
      fetch_ea_i = EA_A; tick("R7");                 // old translation kept
      fetch_ea_i = EA_A2; tick("R3");                // aliasing slot, other tag
      inval_i = 1; inval_ea_i = EA_A2; fetch_ea_i = EA_A; tick("R10");
      fetch_ea_i = EA_A; tick("R8");                 // blind clear
      reload_i = 1; reload_ea_i = EA_A; reload_pte_i = mk_pte(20'h55555, 1, 1, 0);
      inval_i = 1; inval_ea_i = EA_A2; fetch_ea_i = EA_A; tick("R8");
      fetch_ea_i = EA_A; tick("R8");                 // invalidate won

      // random phase over a small colliding pool
      void'($urandom(32'd2024));
      pool[0] = EA_A; pool[1] = EA_A2; pool[2] = EA_B; pool[3] = EA_C;
      pool[4] = EA_D; pool[5] = EA_B ^ 32'h0104_0000;
      pool[6] = 32'h2000_0000; pool[7] = EA_C | 32'h0000_0FF0;
      for (int n = 0; n < 3000; n++) begin
         redirect_i   = ($urandom % 16) == 0;
         redir_virt_i = ($urandom % 4) != 0;
         redir_priv_i = $urandom % 2;
         reload_i     = ($urandom % 3) == 0;
         reload_ea_i  = pool[$urandom % 8];
         reload_pte_i = mk_pte(20'($urandom), ($urandom % 5) != 0, ($urandom % 5) != 0, $urandom % 2);
         inval_i      = ($urandom % 7) == 0;
         inval_ea_i   = pool[$urandom % 8];
         fetch_ea_i   = pool[$urandom % 8] ^ 32'($urandom % 4096);
         tick("R4");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule